// File: doc/BRIEF.md
# Byte-Wide Memory Access Controller

This block connects a microcoded datapath to a single main memory that holds one byte per location and is addressed by 16 bits. The datapath never asks for an access directly. It writes a high address byte and, for stores, a byte of write data into holding registers. It then loads the low address byte through one of two destination codes, and that load is also the start of the access. One code starts a read and the other starts a write. The address presented to memory is the high byte followed by the low byte, and it is captured together with the write data at the moment the access starts.

Every access runs for a fixed latency of two cycles, counted from the cycle that starts it, and `busy` is high for both of them. A read returns its byte in the second cycle, which is flagged by `data_valid`. In that cycle only, a two-bit memory-destination selector coming from the current control word decides where the byte goes. The selector can load nothing, load the memory-data register, or load the memory-data register together with the low address register. Its widest setting also loads the instruction register, so one byte can reach three registers in the same cycle. A start request that arrives while an access is already running is dropped and sets a sticky error flag.

The sequencer has five states. ST_IDLE waits for a start. A read start moves it to ST_RD_WAIT and a write start moves it to ST_WR_WAIT. ST_RD_WAIT pulses the read strobe in its first cycle and moves to ST_RD_DATA once the latency count expires. ST_WR_WAIT does the same with the write strobe and moves to ST_WR_DONE. ST_RD_DATA and ST_WR_DONE both return to ST_IDLE after one cycle. A start seen outside ST_IDLE causes no transition and sets the error flag.

Top module: `byte_mem_port`

## Requirements
- R1: After reset all holding registers (high address, low address, write data, memory data, instruction) read 0, `busy`, `data_valid`, `mem_rd`, `mem_wr` and `overlap_err` are 0.
- R2: Destination code 10 loads `dp_bus` into the high address register and code 15 loads it into the write-data register; any other code except 11 and 13 changes none of the holding registers and starts nothing.
- R3: Destination code 11 while idle loads `dp_bus` into the low address register and, in the next cycle, drives `mem_rd` high for one cycle with `mem_addr` = {high, low} and `busy` high.
- R4: Destination code 13 while idle loads the low address register and, in the next cycle, drives `mem_wr` high for one cycle with `mem_addr` = {high, low} and `mem_wdata` = write-data register; a write never changes the memory-data register, and `mem_rd`/`mem_wr` are never high together.
- R5: `data_valid` is high exactly in the second cycle of a read (two cycles after the start cycle); `busy` is high in both access cycles; selector value 0 in that cycle loads nothing.
- R6: In the data-valid cycle selector 1 loads `mem_rdata` into the memory-data register, 2 loads it into memory-data and low address, 3 loads it into memory-data, low address and instruction registers.
- R7: A nonzero selector outside the data-valid cycle changes none of the memory-data, low address or instruction registers.
- R8: A start code (11 or 13) while `busy` is ignored: the low address register keeps its value, no strobe follows, and `overlap_err` rises and stays high until reset.
- R9: The address and write data used by an access are captured at its start; loading the high address or write-data register during the access leaves `mem_addr` and `mem_wdata` unchanged until it ends.
- R10: A start in the first cycle after the final cycle of an access is accepted without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_sel | input | 4 | Datapath destination code of the current control word |
| dp_bus | input | 8 | Datapath result byte written by the destination code |
| mbus_sel | input | 2 | Memory-destination selector of the current control word |
| mem_rdata | input | 8 | Byte returned by memory |
| mem_addr | output | 16 | Captured access address {high, low} |
| mem_wdata | output | 8 | Captured write byte |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| hi_addr_q | output | 8 | High address register |
| lo_addr_q | output | 8 | Low address register |
| wr_data_q | output | 8 | Write-data register |
| mem_data_q | output | 8 | Memory-data register |
| instr_q | output | 8 | Instruction register |
| busy | output | 1 | An access is in progress |
| data_valid | output | 1 | Read data is valid on `mem_rdata` this cycle |
| overlap_err | output | 1 | Sticky flag: a start arrived while busy |

## Verification
Reads are run with each of the four selector values so that loading nothing, loading one register, loading two and loading three can each be told apart from the others. In the wait cycle of each read the selector is held at its widest value, which would expose any capture taken one cycle early. Writes are mixed in, and the high address and write-data registers are reloaded while a write is running, so a design that reads them live at strobe time rather than capturing them at the start fails. A start issued in the cycle right after an access finishes, and starts issued in each of the two busy cycles, together fix the busy window by cycle on both sides.

// File: rtl/byte_mem_pkg.sv
package byte_mem_pkg;

    localparam int DST_W = 4;
    localparam int MSEL_W = 2;

    // datapath destination codes decoded here
    localparam logic [DST_W-1:0] DST_HI_ADDR = 4'd10;
    localparam logic [DST_W-1:0] DST_LO_READ = 4'd11;
    localparam logic [DST_W-1:0] DST_LO_WRITE = 4'd13;
    localparam logic [DST_W-1:0] DST_WR_DATA = 4'd15;

    // memory-destination selector codes
    localparam logic [MSEL_W-1:0] MSEL_NONE = 2'd0;
    localparam logic [MSEL_W-1:0] MSEL_MD = 2'd1;
    localparam logic [MSEL_W-1:0] MSEL_MD_LO = 2'd2;
    localparam logic [MSEL_W-1:0] MSEL_MD_LO_IR = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR_WAIT,
        ST_WR_DONE
    } acc_state_t;

endpackage

// File: rtl/byte_mem_seq.sv
module byte_mem_seq
    import byte_mem_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    output logic accept,
    output logic busy,
    output logic rd_strobe,
    output logic wr_strobe,
    output logic data_valid,
    output logic overlap_err
);

    localparam int CNT_W = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 2);

    acc_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic start_any;

    assign start_any = start_rd | start_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_rd) begin
                    state_d = ST_RD_WAIT;
                end else if (start_wr) begin
                    state_d = ST_WR_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_RD_DATA;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RD_DATA: state_d = ST_IDLE;
            ST_WR_WAIT: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_WR_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WR_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        busy = 1'b1;
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        data_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                accept = start_any;
            end
            ST_RD_WAIT: rd_strobe = (cnt_q == '0);
            ST_RD_DATA: data_valid = 1'b1;
            ST_WR_WAIT: wr_strobe = (cnt_q == '0);
            ST_WR_DONE: ;
            default: busy = 1'b0;
        endcase
    end

    // sticky overlap flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overlap_err <= 1'b0;
        end else if (start_any && busy) begin
            overlap_err <= 1'b1;
        end
    end

    p_strobe_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rd_strobe || wr_strobe));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_strobe, wr_strobe}));

    p_valid_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> busy);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);

    p_busy_start_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_strobe && !wr_strobe) |=> (!rd_strobe && !wr_strobe));

endmodule

// File: rtl/byte_mem_addr.sv
module byte_mem_addr #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_hi,
    input  logic ld_wd,
    input  logic start_any,
    input  logic accept,
    input  logic busy,
    input  logic lo_from_mem,
    input  logic [DATA_W-1:0] dp_bus,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] wd_q,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            wd_q <= '0;
        end else begin
            if (ld_hi) hi_q <= dp_bus;
            if (ld_wd) wd_q <= dp_bus;
        end
    end

    // low byte: from datapath at start, or from memory by steering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (accept) begin
            lo_q <= dp_bus;
        end else if (lo_from_mem) begin
            lo_q <= mem_rdata;
        end
    end

    // access capture at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr <= '0;
            acc_wdata <= '0;
        end else if (accept) begin
            acc_addr <= {hi_q, dp_bus};
            acc_wdata <= wd_q;
        end
    end

    p_ignored_start_keeps_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_any && !accept && !lo_from_mem) |=> $stable(lo_q));

    p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(acc_addr) && $stable(acc_wdata)));

endmodule

// File: rtl/byte_mem_steer.sv
module byte_mem_steer
    import byte_mem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_valid,
    input  logic [MSEL_W-1:0] mbus_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic lo_from_mem,
    output logic [DATA_W-1:0] md_q,
    output logic [DATA_W-1:0] ir_q
);

    logic ld_md, ld_ir;

    always_comb begin
        ld_md = 1'b0;
        lo_from_mem = 1'b0;
        ld_ir = 1'b0;
        if (data_valid) begin
            unique case (mbus_sel)
                MSEL_NONE: ;
                MSEL_MD: ld_md = 1'b1;
                MSEL_MD_LO: begin
                    ld_md = 1'b1;
                    lo_from_mem = 1'b1;
                end
                MSEL_MD_LO_IR: begin
                    ld_md = 1'b1;
                    lo_from_mem = 1'b1;
                    ld_ir = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= '0;
            ir_q <= '0;
        end else begin
            if (ld_md) md_q <= mem_rdata;
            if (ld_ir) ir_q <= mem_rdata;
        end
    end

    p_no_capture_outside_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |=> ($stable(md_q) && $stable(ir_q)));

endmodule

// File: rtl/byte_mem_port.sv
module byte_mem_port
    import byte_mem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W,
    parameter int ACC_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [DST_W-1:0] dst_sel,
    input  logic [DATA_W-1:0] dp_bus,
    input  logic [MSEL_W-1:0] mbus_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic mem_rd,
    output logic mem_wr,
    output logic [DATA_W-1:0] hi_addr_q,
    output logic [DATA_W-1:0] lo_addr_q,
    output logic [DATA_W-1:0] wr_data_q,
    output logic [DATA_W-1:0] mem_data_q,
    output logic [DATA_W-1:0] instr_q,
    output logic busy,
    output logic data_valid,
    output logic overlap_err
);

    logic start_rd, start_wr, start_any, accept, lo_from_mem;
    logic ld_hi, ld_wd;

    assign start_rd = (dst_sel == DST_LO_READ);
    assign start_wr = (dst_sel == DST_LO_WRITE);
    assign start_any = start_rd | start_wr;
    assign ld_hi = (dst_sel == DST_HI_ADDR);
    assign ld_wd = (dst_sel == DST_WR_DATA);

    byte_mem_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .start_rd(start_rd),
        .start_wr(start_wr),
        .accept(accept),
        .busy(busy),
        .rd_strobe(mem_rd),
        .wr_strobe(mem_wr),
        .data_valid(data_valid),
        .overlap_err(overlap_err)
    );

    byte_mem_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk),
        .rst_n(rst_n),
        .ld_hi(ld_hi),
        .ld_wd(ld_wd),
        .start_any(start_any),
        .accept(accept),
        .busy(busy),
        .lo_from_mem(lo_from_mem),
        .dp_bus(dp_bus),
        .mem_rdata(mem_rdata),
        .hi_q(hi_addr_q),
        .lo_q(lo_addr_q),
        .wd_q(wr_data_q),
        .acc_addr(mem_addr),
        .acc_wdata(mem_wdata)
    );

    byte_mem_steer #(.DATA_W(DATA_W)) u_steer (
        .clk(clk),
        .rst_n(rst_n),
        .data_valid(data_valid),
        .mbus_sel(mbus_sel),
        .mem_rdata(mem_rdata),
        .lo_from_mem(lo_from_mem),
        .md_q(mem_data_q),
        .ir_q(instr_q)
    );

    p_write_keeps_md_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(mem_data_q));

    p_fan_lo_agrees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && mbus_sel[1]) |=> (lo_addr_q == mem_data_q));

    p_fan_ir_agrees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && mbus_sel == MSEL_MD_LO_IR) |=> (instr_q == mem_data_q));

    p_idle_after_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_any && !busy) |=> busy);

endmodule

// File: tb/byte_mem_port_tb.sv
module byte_mem_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_DEPTH = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] dst_sel = '0;
    logic [7:0] dp_bus = '0;
    logic [1:0] mbus_sel = '0;
    logic [7:0] mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic mem_rd, mem_wr;
    logic [7:0] hi_addr_q, lo_addr_q, wr_data_q, mem_data_q, instr_q;
    logic busy, data_valid, overlap_err;

    int n_tests = 0;
    int n_fail = 0;

    logic [7:0] model_mem [MEM_DEPTH];
    logic [7:0] shadow [MEM_DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    byte_mem_port dut_i (
        .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .dp_bus(dp_bus),
        .mbus_sel(mbus_sel), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .hi_addr_q(hi_addr_q), .lo_addr_q(lo_addr_q), .wr_data_q(wr_data_q),
        .mem_data_q(mem_data_q), .instr_q(instr_q), .busy(busy),
        .data_valid(data_valid), .overlap_err(overlap_err)
    );

    function automatic logic [7:0] init_byte(input int idx);
        return 8'((idx * 37 + 11) & 255);
    endfunction

    // memory model: registered read one cycle after the strobe
    initial begin
        mem_rdata = '0;
        for (int i = 0; i < MEM_DEPTH; i++) begin
            model_mem[i] = init_byte(i);
            shadow[i] = init_byte(i);
        end
    end

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= model_mem[mem_addr[9:0]];
        if (mem_wr) model_mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] d, input logic [7:0] b, input logic [1:0] s);
        dst_sel = d;
        dp_bus = b;
        mbus_sel = s;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        dst_sel = '0;
        dp_bus = '0;
        mbus_sel = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(hi_addr_q == 0 && lo_addr_q == 0 && wr_data_q == 0, "R1 addr/wdata regs",
            {hi_addr_q, lo_addr_q}, 16'h0);
        chk(mem_data_q == 0 && instr_q == 0, "R1 md/ir regs", {mem_data_q, instr_q}, 16'h0);
        chk({busy, data_valid, mem_rd, mem_wr, overlap_err} == 5'b0, "R1 status lines",
            16'({busy, data_valid, mem_rd, mem_wr, overlap_err}), 16'h0);
    endtask

    task automatic t_reg_loads();
        step(4'd10, 8'h12, 2'd0);
        chk(hi_addr_q == 8'h12, "R2 high address load", 16'(hi_addr_q), 16'h12);
        step(4'd15, 8'hA5, 2'd0);
        chk(wr_data_q == 8'hA5, "R2 write-data load", 16'(wr_data_q), 16'hA5);
        step(4'd4, 8'h77, 2'd0);
        step(4'd12, 8'h66, 2'd0);
        chk(hi_addr_q == 8'h12 && wr_data_q == 8'hA5 && lo_addr_q == 8'h00,
            "R2 other codes ignored", {hi_addr_q, wr_data_q}, 16'h12A5);
        chk(!busy && !mem_rd && !mem_wr, "R2 other codes start nothing",
            16'({busy, mem_rd, mem_wr}), 16'h0);
    endtask

    task automatic t_read(input logic [7:0] hi, input logic [7:0] lo, input logic [1:0] sel);
        logic [7:0] md0, ir0, exp;
        step(4'd10, hi, 2'd0);
        md0 = mem_data_q;
        ir0 = instr_q;
        exp = shadow[int'({hi[1:0], lo})];
        step(4'd11, lo, 2'd0);
        chk(lo_addr_q == lo, "R3 low address loaded at start", 16'(lo_addr_q), 16'(lo));
        chk(mem_rd && !mem_wr && busy, "R3 read strobe and busy", 16'({mem_rd, mem_wr, busy}), 16'b101);
        chk(mem_addr == {hi, lo}, "R3 read address", mem_addr, {hi, lo});
        step(4'd0, 8'h00, 2'd3);
        chk(data_valid && busy && !mem_rd, "R5 data valid in second cycle",
            16'({data_valid, busy, mem_rd}), 16'b110);
        chk(mem_data_q == md0 && instr_q == ir0 && lo_addr_q == lo, "R7 early selector ignored",
            {mem_data_q, instr_q}, {md0, ir0});
        step(4'd0, 8'h00, sel);
        chk(!busy && !data_valid, "R5 access ends after two cycles", 16'({busy, data_valid}), 16'h0);
        if (sel == 2'd0) begin
            chk(mem_data_q == md0 && lo_addr_q == lo && instr_q == ir0, "R5 selector 0 loads nothing",
                {mem_data_q, lo_addr_q}, {md0, lo});
        end else begin
            chk(mem_data_q == exp, "R6 memory-data capture", 16'(mem_data_q), 16'(exp));
            chk(lo_addr_q == ((sel >= 2'd2) ? exp : lo), "R6 low address steering",
                16'(lo_addr_q), 16'((sel >= 2'd2) ? exp : lo));
            chk(instr_q == ((sel == 2'd3) ? exp : ir0), "R6 instruction steering",
                16'(instr_q), 16'((sel == 2'd3) ? exp : ir0));
        end
    endtask

    task automatic t_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] wd);
        logic [7:0] md0;
        step(4'd10, hi, 2'd0);
        step(4'd15, wd, 2'd0);
        md0 = mem_data_q;
        step(4'd13, lo, 2'd0);
        chk(mem_wr && !mem_rd && busy, "R4 write strobe", 16'({mem_wr, mem_rd, busy}), 16'b101);
        chk(mem_addr == {hi, lo} && mem_wdata == wd, "R4 write address and data",
            mem_addr, {hi, lo});
        shadow[int'({hi[1:0], lo})] = wd;
        step(4'd10, ~hi, 2'd1);
        chk(mem_addr == {hi, lo} && hi_addr_q == ~hi, "R9 address held during access",
            mem_addr, {hi, lo});
        step(4'd15, ~wd, 2'd1);
        chk(mem_data_q == md0, "R4 write leaves memory-data register", 16'(mem_data_q), 16'(md0));
        chk(mem_wdata == wd, "R9 write data held after reload", 16'(mem_wdata), 16'(wd));
        chk(model_mem[int'({hi[1:0], lo})] == wd, "R4 memory updated",
            16'(model_mem[int'({hi[1:0], lo})]), 16'(wd));
        step(4'd0, 8'h00, 2'd0);
    endtask

    task automatic t_back_to_back();
        logic [7:0] e2;
        step(4'd10, 8'h01, 2'd0);
        step(4'd11, 8'h55, 2'd0);
        step(4'd0, 8'h00, 2'd0);
        step(4'd0, 8'h00, 2'd1);
        e2 = shadow[int'({2'b01, 8'h66})];
        step(4'd11, 8'h66, 2'd0);
        chk(mem_rd && !overlap_err && lo_addr_q == 8'h66, "R10 start right after access accepted",
            16'({mem_rd, overlap_err}), 16'b10);
        step(4'd0, 8'h00, 2'd0);
        step(4'd0, 8'h00, 2'd1);
        chk(mem_data_q == e2, "R10 second read data", 16'(mem_data_q), 16'(e2));
    endtask

    task automatic t_overlap();
        logic [7:0] e;
        step(4'd10, 8'h01, 2'd0);
        e = shadow[int'({2'b01, 8'h40})];
        step(4'd11, 8'h40, 2'd0);
        step(4'd13, 8'h99, 2'd0);
        chk(overlap_err && lo_addr_q == 8'h40, "R8 start in first busy cycle ignored",
            16'({overlap_err, lo_addr_q}), 16'h140);
        step(4'd11, 8'h41, 2'd1);
        chk(lo_addr_q == 8'h40 && mem_data_q == e && !busy, "R8 start in data cycle ignored",
            {lo_addr_q, mem_data_q}, {8'h40, e});
        chk(!mem_rd && !mem_wr, "R8 no strobe from ignored start", 16'({mem_rd, mem_wr}), 16'h0);
        step(4'd0, 8'h00, 2'd0);
        step(4'd0, 8'h00, 2'd0);
        chk(overlap_err, "R8 error flag sticky", 16'(overlap_err), 16'h1);
        t_reset();
        chk(!overlap_err, "R1 reset clears error flag", 16'(overlap_err), 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_reg_loads();
        t_read(8'h01, 8'h23, 2'd1);
        t_read(8'h02, 8'h34, 2'd0);
        t_read(8'h03, 8'h45, 2'd2);
        t_read(8'h00, 8'h9C, 2'd3);
        t_write(8'h02, 8'h10, 8'h5A);
        t_read(8'h02, 8'h10, 2'd1);
        t_write(8'h01, 8'hF0, 8'hC3);
        t_read(8'h01, 8'hF0, 2'd3);
        t_back_to_back();
        t_overlap();
        t_read(8'h03, 8'h07, 2'd2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule